// File: doc/BRIEF.md
# Bitfield Read-Modify-Write Sequencer

This block carries out the memory half of a bitfield set or bitfield insert. It takes a base byte address, a signed bit offset, a field length of 1 to 32 bits and the new field value. From these it locates a 40-bit window in a byte-addressed memory. The window is a 32-bit word followed by one extra byte, so a field that starts anywhere inside a byte and runs up to 32 bits always fits. The block reads the window, splices the new value into it and writes the word back. It writes the extra byte only when the field actually reaches into it.

The bits that the field covered before the write are returned right-justified, together with negative, zero, overflow and carry flags for the condition-code logic. A single request/acknowledge port carries all traffic, with long (32-bit) and byte transfers. Instruction decode and effective-address calculation happen elsewhere: the block is handed a finished base address.

Top module: `bfrmw_seq`

## Requirements
- R1: While reset is low and after its release, `busy`, `done` and `bus_req` are low.
- R2: The field's byte address A equals the base address plus the bit offset shifted arithmetically right by three, so negative offsets reach below the base. Every bus address is truncated to its low PHYS_W bits (default 24), and the bits above them are zero.
- R3: An operation makes its accesses in this fixed order: a long read at A, a byte read at A+4, a long write at A, and an optional byte write at A+4. Each request holds `bus_req`, `bus_addr`, `bus_we` and `bus_size` steady until `bus_ack` is seen. `bus_size` is 1 for long and 0 for byte.
- R4: A long transfer is big-endian, with the byte at the lowest address in bits 31:24. The field starts at bit (offset mod 8) counted from the top of the word and runs downward. In the word written back, every bit outside the field keeps the value that was read.
- R5: The byte at A+4 is written only when (offset mod 8) plus length exceeds 32. Byte data travels on bits 7:0 of `bus_rdata` and `bus_wdata`, and a byte write drives bits 31:8 of `bus_wdata` to zero. In the byte written, the bits below the field are preserved.
- R6: When `done` is high, `old_field` holds the field's value before the write, right-justified. `flag_n` equals its top bit and `flag_z` is high when it is zero. `flag_v` and `flag_c` are low.
- R7: A length code of 0 means 32 bits, and any other code is the length itself. Only the low length bits of `fld_data` are written.
- R8: `busy` rises in the cycle after an accepted `start` and stays high through the single cycle in which `done` is high. After that cycle both are low. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| base_addr | input | ADDR_W | Base byte address |
| bit_off | input | 32 | Signed bit offset from base |
| fld_len | input | 5 | Field length, 0 encodes 32 |
| fld_data | input | 32 | New field value, right-justified |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| old_field | output | 32 | Previous field contents, right-justified |
| flag_n | output | 1 | Top bit of previous field |
| flag_z | output | 1 | Previous field was zero |
| flag_v | output | 1 | Overflow flag, always low |
| flag_c | output | 1 | Carry flag, always low |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Write when high, read when low |
| bus_size | output | 1 | 1 long, 0 byte |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Read data |

## Verification
The two events that can share a cycle are a new `start` from the requester and a bus acknowledge that moves the sequencer into its next access. The bench provokes this by driving `start`, with different operands, in the same cycle that a zero-latency responder acknowledges the first read. It then judges the outcome from the access log and the final memory image: both must match the original operation alone, with no extra or displaced transfer. Each operation also runs with acknowledge latencies of zero to two cycles, so that a request held across waits is checked against each access.

// File: rtl/bfrmw_pkg.sv
package bfrmw_pkg;
   localparam int DATA_W = 32;
   localparam int WIN_W  = DATA_W + 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_W,
      ST_RD_B,
      ST_WR_W,
      ST_WR_B,
      ST_DONE
   } bfrmw_state_e;
endpackage

// File: rtl/bfrmw_agen.sv
module bfrmw_agen #(
   parameter int ADDR_W = 32,
   parameter int PHYS_W = 24
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [31:0]       bit_off,
   output logic [ADDR_W-1:0] lo_addr,
   output logic [ADDR_W-1:0] hi_addr
);
   localparam int BYTE_SHIFT = 3;

   logic [ADDR_W-1:0] byte_idx;
   logic [ADDR_W-1:0] raw_lo;
   logic [ADDR_W-1:0] raw_hi;

   assign byte_idx = ADDR_W'($signed(bit_off) >>> BYTE_SHIFT);
   assign raw_lo   = base_addr + byte_idx;
   assign raw_hi   = raw_lo + ADDR_W'(4);

   generate
      if (PHYS_W < ADDR_W) begin : g_trunc
         assign lo_addr = {{(ADDR_W-PHYS_W){1'b0}}, raw_lo[PHYS_W-1:0]};
         assign hi_addr = {{(ADDR_W-PHYS_W){1'b0}}, raw_hi[PHYS_W-1:0]};
      end else begin : g_full
         assign lo_addr = raw_lo;
         assign hi_addr = raw_hi;
      end
   endgenerate
endmodule

// File: rtl/bfrmw_merge.sv
module bfrmw_merge
   import bfrmw_pkg::*;
(
   input  logic [DATA_W-1:0] word_in,
   input  logic [7:0]        byte_in,
   input  logic [2:0]        sh,
   input  logic [4:0]        len,
   input  logic [DATA_W-1:0] pattern,
   output logic [DATA_W-1:0] word_out,
   output logic [7:0]        byte_out,
   output logic              spill,
   output logic [DATA_W-1:0] old_field,
   output logic              flag_n,
   output logic              flag_z
);
   logic [5:0]       width;
   logic [5:0]       lo_pos;
   logic [WIN_W-1:0] win, ones, fmask, ins, merged, pulled;

   assign width  = (len == 5'd0) ? 6'd32 : {1'b0, len};
   // lowest window bit covered by the field (window bit 39 is the word MSB)
   assign lo_pos = 6'(WIN_W) - {3'b000, sh} - width;

   assign win    = {word_in, byte_in};
   assign ones   = (WIN_W'(1) << width) - WIN_W'(1);
   assign fmask  = ones << lo_pos;
   assign ins    = (WIN_W'(pattern) & ones) << lo_pos;
   assign merged = (win & ~fmask) | ins;
   assign pulled = (win & fmask) >> lo_pos;

   assign word_out  = merged[WIN_W-1:8];
   assign byte_out  = merged[7:0];
   assign old_field = pulled[DATA_W-1:0];
   assign flag_n    = old_field[5'(width - 6'd1)];
   assign flag_z    = (old_field == '0);
   assign spill     = ({1'b0, width} + 7'(sh)) > 7'd32;
endmodule

// File: rtl/bfrmw_fsm.sv
module bfrmw_fsm
   import bfrmw_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         bus_ack,
   input  logic         spill,
   output bfrmw_state_e state,
   output logic         ld_op,
   output logic         cap_word,
   output logic         cap_byte
);
   bfrmw_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (start)   nxt = ST_RD_W;
         ST_RD_W: if (bus_ack) nxt = ST_RD_B;
         ST_RD_B: if (bus_ack) nxt = ST_WR_W;
         ST_WR_W: if (bus_ack) nxt = spill ? ST_WR_B : ST_DONE;
         ST_WR_B: if (bus_ack) nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign ld_op    = (state == ST_IDLE) && start;
   assign cap_word = (state == ST_RD_W) && bus_ack;
   assign cap_byte = (state == ST_RD_B) && bus_ack;
endmodule

// File: rtl/bfrmw_seq.sv
module bfrmw_seq
   import bfrmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PHYS_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [31:0]       bit_off,
   input  logic [4:0]        fld_len,
   input  logic [31:0]       fld_data,
   output logic              busy,
   output logic              done,
   output logic [31:0]       old_field,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_size,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [31:0]       bus_rdata
);
   generate
      if (PHYS_W < 8 || PHYS_W > ADDR_W) begin : g_bad_phys
         $error("bfrmw_seq: PHYS_W must lie between 8 and ADDR_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("bfrmw_seq: ADDR_W too small");
      end
   endgenerate

   bfrmw_state_e      state;
   logic              ld_op, cap_word, cap_byte, spill;
   logic [ADDR_W-1:0] lo_next, hi_next, lo_q, hi_q;
   logic [2:0]        sh_q;
   logic [4:0]        len_q;
   logic [31:0]       pat_q, word_q, new_word;
   logic [7:0]        byte_q, new_byte;

   bfrmw_agen #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_agen (
      .base_addr (base_addr),
      .bit_off   (bit_off),
      .lo_addr   (lo_next),
      .hi_addr   (hi_next)
   );

   bfrmw_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .bus_ack  (bus_ack),
      .spill    (spill),
      .state    (state),
      .ld_op    (ld_op),
      .cap_word (cap_word),
      .cap_byte (cap_byte)
   );

   bfrmw_merge u_merge (
      .word_in   (word_q),
      .byte_in   (byte_q),
      .sh        (sh_q),
      .len       (len_q),
      .pattern   (pat_q),
      .word_out  (new_word),
      .byte_out  (new_byte),
      .spill     (spill),
      .old_field (old_field),
      .flag_n    (flag_n),
      .flag_z    (flag_z)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         sh_q   <= '0;
         len_q  <= '0;
         pat_q  <= '0;
         word_q <= '0;
         byte_q <= '0;
      end else begin
         if (ld_op) begin
            lo_q  <= lo_next;
            hi_q  <= hi_next;
            sh_q  <= bit_off[2:0];
            len_q <= fld_len;
            pat_q <= fld_data;
         end
         if (cap_word) word_q <= bus_rdata;
         if (cap_byte) byte_q <= bus_rdata[7:0];
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign flag_v   = 1'b0;
   assign flag_c   = 1'b0;
   assign bus_req  = (state == ST_RD_W) || (state == ST_RD_B) ||
                     (state == ST_WR_W) || (state == ST_WR_B);
   assign bus_we   = (state == ST_WR_W) || (state == ST_WR_B);
   assign bus_size = (state == ST_RD_W) || (state == ST_WR_W);
   assign bus_addr = ((state == ST_RD_B) || (state == ST_WR_B)) ? hi_q : lo_q;
   assign bus_wdata = (state == ST_WR_W) ? new_word :
                      (state == ST_WR_B) ? {24'h0, new_byte} : 32'h0;

   // R3: a request is held unchanged until acknowledged
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

   // R5: a byte write happens only when the field spills into the fifth byte
   assert_byte_wr_spill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && !bus_size |-> spill && (bus_wdata[31:8] == 24'h0));

   // R8: completion lasts one cycle and returns to idle
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R8: a start while busy does not disturb the latched operands
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(pat_q) && $stable(lo_q) && $stable(len_q));

   generate
      if (PHYS_W < ADDR_W) begin : g_chk_trunc
         // R2: no address bit above the physical range is ever driven
         assert_addr_trunc_R2: assert property (@(posedge clk) disable iff (!rst_n)
            bus_req |-> (bus_addr[ADDR_W-1:PHYS_W] == '0));
      end
   endgenerate
endmodule

// File: tb/bfrmw_seq_test.sv
`timescale 1ns/1ps
module bfrmw_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [31:0] bit_off = '0;
   logic [4:0]  fld_len = '0;
   logic [31:0] fld_data = '0;
   logic        busy, done, flag_n, flag_z, flag_v, flag_c;
   logic [31:0] old_field;
   logic        bus_req, bus_we, bus_size;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int vectors = 0;
   int miscompares = 0;

   always #2.5 clk = ~clk;

   bfrmw_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .bit_off(bit_off), .fld_len(fld_len), .fld_data(fld_data),
      .busy(busy), .done(done), .old_field(old_field), .flag_n(flag_n),
      .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .bus_req(bus_req),
      .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   // memory model: 256 bytes, indexed by the low address byte
   logic [7:0]  mem [0:255];
   logic [7:0]  exp_mem [0:255];
   logic [31:0] acc_addr [0:7];
   logic        acc_we [0:7];
   logic        acc_sz [0:7];
   int          acc_n = 0;
   int          hi_dirty = 0;
   int          lat = 0;
   int          wcnt = 0;
   logic [7:0]  a;

   always @(negedge clk) begin
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
         if (wcnt < lat) wcnt++;
         else begin
            wcnt = 0;
            a = bus_addr[7:0];
            if (acc_n < 8) begin
               acc_addr[acc_n] = bus_addr;
               acc_we[acc_n]   = bus_we;
               acc_sz[acc_n]   = bus_size;
            end
            acc_n++;
            if (bus_we) begin
               if (bus_size) begin
                  mem[a] = bus_wdata[31:24]; mem[8'(a+1)] = bus_wdata[23:16];
                  mem[8'(a+2)] = bus_wdata[15:8]; mem[8'(a+3)] = bus_wdata[7:0];
               end else begin
                  mem[a] = bus_wdata[7:0];
                  if (bus_wdata[31:8] != 24'h0) hi_dirty++;
               end
            end else if (bus_size)
               bus_rdata = {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
            else
               bus_rdata = {24'hA5C3E1, mem[a]};
            bus_ack = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !bus_req, "R1 state in reset", {busy, done, bus_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !bus_req, "R1 state after reset", {busy, done, bus_req}, 0);
   endtask

   task automatic run_op(input logic [31:0] base, input int off, input logic [4:0] len,
                         input logic [31:0] pat, input int latency, input bit poke, input string name);
      int          sh, q, w, t, nexp, bad, badi;
      logic [31:0] A, A4, exp_old;
      logic [39:0] win;
      bit          sp;
      lat = latency;
      sh = off & 7;
      q = (off - sh) / 8;
      w = (len == 0) ? 32 : int'(len);
      A = (base + 32'(q)) & 32'h00FF_FFFF;
      A4 = (A + 32'd4) & 32'h00FF_FFFF;
      for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
      for (int k = 0; k < 5; k++) win[39-8*k -: 8] = mem[8'(A[7:0] + 8'(k))];
      exp_old = '0;
      for (int i = 0; i < w; i++) begin
         exp_old[w-1-i] = win[39-sh-i];
         win[39-sh-i] = pat[w-1-i];
      end
      sp = (sh + w) > 32;
      for (int k = 0; k < (sp ? 5 : 4); k++) exp_mem[8'(A[7:0] + 8'(k))] = win[39-8*k -: 8];
      nexp = sp ? 4 : 3;
      acc_n = 0;
      hi_dirty = 0;

      @(negedge clk);
      base_addr = base; bit_off = 32'(off); fld_len = len; fld_data = pat; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, {"R8 busy after start ", name}, busy, 1);
      if (poke) begin
         // new start coinciding with the first acknowledge: must be ignored
         start = 1'b1; base_addr = base + 32'h40; bit_off = 32'(off + 9);
         fld_len = len + 5'd1; fld_data = ~pat;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done && t < 1000) begin @(negedge clk); t++; end
      if (!done) begin
         chk(0, {"R8 no completion ", name}, t, 0);
         return;
      end
      chk(busy, {"R8 busy during done ", name}, busy, 1);
      chk(old_field == exp_old, {"R6 old field ", name}, old_field, exp_old);
      chk(flag_n == exp_old[w-1], {"R6 N flag ", name}, flag_n, exp_old[w-1]);
      chk(flag_z == (exp_old == 0), {"R6 Z flag ", name}, flag_z, exp_old == 0);
      chk(!flag_v && !flag_c, {"R6 V/C clear ", name}, {flag_v, flag_c}, 0);
      @(negedge clk);
      chk(!done && !busy, {"R8 done single cycle ", name}, {done, busy}, 0);
      chk(acc_n == nexp, {"R5 access count ", name}, acc_n, nexp);
      if (acc_n >= 3) begin
         chk(acc_addr[0] == A && !acc_we[0] && acc_sz[0], {"R3 first access long read ", name},
             {acc_addr[0], acc_we[0], acc_sz[0]}, {A, 1'b0, 1'b1});
         chk(acc_addr[1] == A4 && !acc_we[1] && !acc_sz[1], {"R3 second access byte read ", name},
             {acc_addr[1], acc_we[1], acc_sz[1]}, {A4, 1'b0, 1'b0});
         chk(acc_addr[2] == A && acc_we[2] && acc_sz[2], {"R2 long write address ", name},
             {acc_addr[2], acc_we[2], acc_sz[2]}, {A, 1'b1, 1'b1});
      end
      if (sp && acc_n == 4)
         chk(acc_addr[3] == A4 && acc_we[3] && !acc_sz[3], {"R5 byte write ", name},
             {acc_addr[3], acc_we[3], acc_sz[3]}, {A4, 1'b1, 1'b0});
      chk(hi_dirty == 0, {"R5 byte write upper lanes zero ", name}, hi_dirty, 0);
      bad = 0; badi = 0;
      for (int k = 0; k < 256; k++)
         if (mem[k] !== exp_mem[k]) begin if (bad == 0) badi = k; bad++; end
      chk(bad == 0, {"R4 memory image ", name}, {badi[15:0], mem[badi]}, {badi[15:0], exp_mem[badi]});
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 8'(k * 29 + 3);
      t_reset();
      run_op(32'h0000_1040, 0,   5'd8,  32'h0000_005A, 0, 0, "aligned byte");
      run_op(32'h0000_1040, 11,  5'd12, 32'hFFFF_FABC, 1, 0, "R7 pattern upper bits");
      run_op(32'h0000_1060, 4,   5'd28, 32'h0123_4567, 2, 0, "exact 32 boundary");
      run_op(32'h0000_1070, 13,  5'd0,  32'hDEAD_BEEF, 0, 0, "R7 length 32 spill");
      run_op(32'h0000_1090, -3,  5'd6,  32'h0000_002A, 1, 0, "R2 small negative");
      run_op(32'h0000_10A0, -70, 5'd20, 32'h0009_5555, 0, 0, "R2 large negative");
      run_op(32'h0000_10B0, 7,   5'd30, 32'hFFFF_FFFF, 1, 0, "set all spill");
      run_op(32'h0000_10B0, 7,   5'd30, 32'h0000_0000, 2, 0, "clear after set N");
      run_op(32'h0000_10B0, 7,   5'd30, 32'h1555_5555, 0, 0, "read zero Z");
      run_op(32'h0000_10C0, 21,  5'd17, 32'h0001_3C3C, 0, 1, "R8 start ignored");
      run_op(32'h7FFF_FFF0, 200, 5'd9,  32'h0000_0133, 1, 0, "R2 address truncation");
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end
endmodule